// File: doc/BRIEF.md
# Direct-Mapped Instruction Line Cache

This block is a small, read-only, direct-mapped instruction cache placed between an instruction fetch stage and a Wishbone memory bus. The fetch stage raises a request strobe with a 64-bit byte address. It keeps both steady until the cache acknowledges. The cache answers with a 32-bit instruction word. When the addressed line is resident, the acknowledge and the instruction are produced combinationally, in the same cycle as the request.

On a miss the acknowledge stays low. A refill engine then reads the whole line from memory as a run of 64-bit Wishbone reads. It starts at the line's base address and steps one doubleword per bus acknowledge. Tag and valid state are updated only after the last doubleword has been stored. In the following cycle the request that is still held becomes a hit and is acknowledged.

The line length in doublewords and the number of lines are parameters. With the defaults there are 4 lines of 8 doublewords, so the line index is address bits [7:6] and the tag is bits [63:8].

Top module: `insn_line_cache`

## Requirements
- R1: Synchronous, active-high reset invalidates every line. The first request after reset, including one to address 0, misses, and acknowledge is low in the first cycle after reset.
- R2: A request to a resident line raises `fetch_ack_o` in the same cycle, with no register between the request and the acknowledge. `fetch_insn_o` carries the addressed word in that cycle.
- R3: Address bit 2 picks the half of the 64-bit doubleword. 0 returns bits [31:0] and 1 returns bits [63:32]. Address bits [5:3] pick the doubleword within the line.
- R4: On a miss, acknowledge stays low and a refill starts. The refill performs 8 read transfers with `wb_we_o`=0 and `wb_sel_o`=8'hFF, and `wb_cyc_o` and `wb_stb_o` are high together. The transfer addresses are the line base (the address with bits [5:0] cleared) plus 8 times the beat number, in ascending order.
- R5: While a transfer waits for `wb_ack_i`, the cycle, strobe and address remain unchanged.
- R6: The line becomes valid only after its last doubleword is written. The held request is acknowledged in the cycle after the final bus acknowledge, with the refilled data. With a memory that acknowledges one cycle after each strobe, this happens within 30 cycles of the request.
- R7: The line index is address bits [7:6] and the tag is bits [63:8]. Two addresses with the same index and different tags evict each other, so 0x100 displaces the line holding 0x0. A line with a different index is not affected.
- R8: No bus cycle is started while requests hit or while no request is made.
- R9: `fetch_ack_o` is never high while `wb_cyc_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_i | input | 1 | Fetch request strobe, held until acknowledged |
| fetch_addr_i | input | 64 | Fetch byte address |
| fetch_ack_o | output | 1 | Request satisfied this cycle |
| fetch_insn_o | output | 32 | Instruction word for the request |
| wb_cyc_o | output | 1 | Wishbone bus cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable, always 0 |
| wb_sel_o | output | 8 | Wishbone byte selects, all ones |
| wb_adr_o | output | 64 | Wishbone byte address of the doubleword |
| wb_dat_i | input | 64 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone transfer acknowledge |

## Verification
The final bus acknowledge of a refill does two things in one clock edge: it stores the last doubleword and it marks the line valid. In that same cycle the held fetch request is still being looked up, so the lookup and the completing refill overlap. The bench holds its request through every refill against memory models with acknowledge latencies of 0, 1 and 3 wait cycles. It requires that the acknowledge never coincides with an open bus cycle and that it comes only after all 8 beats. It also requires that the word returned at that point is the freshly refilled one, computed arithmetically from the address.

// File: rtl/insn_cache_pkg.sv
package insn_cache_pkg;

    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;

endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 56
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx_i,
    input  logic [TAG_W-1:0] rd_tag_i,
    output logic             hit_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i
);

    typedef struct packed {
        logic [NUM_LINES-1:0]            vld;
        logic [NUM_LINES-1:0][TAG_W-1:0] tag;
    } tv_t;

    tv_t tv_d, tv_q;

    always_comb begin
        tv_d = tv_q;
        if (wr_en_i) begin
            tv_d.vld[wr_idx_i] = 1'b1;
            tv_d.tag[wr_idx_i] = wr_tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tv_q <= '0;
        end else begin
            tv_q <= tv_d;
        end
    end

    assign hit_o = tv_q.vld[rd_idx_i] && (tv_q.tag[rd_idx_i] == rd_tag_i);

    // R6
    fill_marks_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> tv_q.vld[$past(wr_idx_i)] && (tv_q.tag[$past(wr_idx_i)] == $past(wr_tag_i)));

endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int NUM_LINES   = 4,
    parameter int LINE_DWORDS = 8,
    parameter int DATA_W      = 64,
    parameter int INSN_W      = 32,
    parameter int IDX_W       = 2,
    parameter int CNT_W       = 3,
    parameter int HSEL_W      = 1
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [CNT_W-1:0]  wr_word_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [CNT_W-1:0]  rd_word_i,
    input  logic [HSEL_W-1:0] rd_half_i,
    output logic [INSN_W-1:0] insn_o
);

    localparam int DEPTH  = NUM_LINES * LINE_DWORDS;
    localparam int HALVES = DATA_W / INSN_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_dword;
    logic [INSN_W-1:0] slice [HALVES];

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i) begin
            mem_d[{wr_idx_i, wr_word_i}] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_dword = mem_q[{rd_idx_i, rd_word_i}];

    for (genvar g = 0; g < HALVES; g++) begin : g_slice
        assign slice[g] = rd_dword[g*INSN_W +: INSN_W];
    end

    assign insn_o = slice[rd_half_i];

endmodule

// File: rtl/icache_refill_ctrl.sv
module icache_refill_ctrl
    import insn_cache_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 56,
    parameter int CNT_W  = 3,
    parameter int BYTE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              miss_i,
    input  logic [TAG_W-1:0]  req_tag_i,
    input  logic [IDX_W-1:0]  req_idx_i,
    input  logic              wb_ack_i,
    output logic              wb_cyc_o,
    output logic [ADDR_W-1:0] wb_adr_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [CNT_W-1:0]  wr_word_o,
    output logic              line_set_o,
    output logic [TAG_W-1:0]  line_tag_o
);

    localparam logic [CNT_W-1:0] LAST_BEAT = '1;

    typedef struct packed {
        fill_state_e     st;
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic we_d, set_d;

    always_comb begin
        ctl_d = ctl_q;
        we_d  = 1'b0;
        set_d = 1'b0;
        case (ctl_q.st)
            FILL_IDLE: begin
                if (req_i && miss_i) begin
                    ctl_d.st  = FILL_BUSY;
                    ctl_d.tag = req_tag_i;
                    ctl_d.idx = req_idx_i;
                    ctl_d.cnt = '0;
                end
            end
            FILL_BUSY: begin
                if (wb_ack_i) begin
                    we_d = 1'b1;
                    if (ctl_q.cnt == LAST_BEAT) begin
                        set_d    = 1'b1;
                        ctl_d.st = FILL_IDLE;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + 1'b1;
                    end
                end
            end
            default: ctl_d.st = FILL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wb_cyc_o   = (ctl_q.st == FILL_BUSY);
    assign wb_adr_o   = {ctl_q.tag, ctl_q.idx, ctl_q.cnt, {BYTE_W{1'b0}}};
    assign wr_en_o    = we_d;
    assign wr_idx_o   = ctl_q.idx;
    assign wr_word_o  = ctl_q.cnt;
    assign line_set_o = set_d;
    assign line_tag_o = ctl_q.tag;

    // R5
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wb_cyc_o && !wb_ack_i |=> wb_cyc_o && $stable(wb_adr_o));

    // R4
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        wb_cyc_o && wb_ack_i |=> !wb_cyc_o || (wb_adr_o == $past(wb_adr_o) + ADDR_W'(1 << BYTE_W)));

    // R6
    fill_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(wb_cyc_o) |-> $past(wb_ack_i));

endmodule

// File: rtl/insn_line_cache.sv
module insn_line_cache #(
    parameter int ADDR_W      = 64,
    parameter int DATA_W      = 64,
    parameter int INSN_W      = 32,
    parameter int LINE_DWORDS = 8,
    parameter int NUM_LINES   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req_i,
    input  logic [63:0]       fetch_addr_i,
    output logic              fetch_ack_o,
    output logic [31:0]       fetch_insn_o,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [7:0]        wb_sel_o,
    output logic [63:0]       wb_adr_o,
    input  logic [63:0]       wb_dat_i,
    input  logic              wb_ack_i
);

    localparam int BYTE_W   = $clog2(DATA_W / 8);
    localparam int INSN_LSB = $clog2(INSN_W / 8);
    localparam int HSEL_W   = BYTE_W - INSN_LSB;
    localparam int CNT_W    = $clog2(LINE_DWORDS);
    localparam int OFF_W    = BYTE_W + CNT_W;
    localparam int IDX_W    = $clog2(NUM_LINES);
    localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [CNT_W-1:0]  req_word;
    logic [HSEL_W-1:0] req_half;
    logic [INSN_LSB-1:0] unused_lsbs;

    logic              hit;
    logic              busy;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [CNT_W-1:0]  wr_word;
    logic              line_set;
    logic [TAG_W-1:0]  line_tag;

    assign req_tag     = fetch_addr_i[ADDR_W-1 -: TAG_W];
    assign req_idx     = fetch_addr_i[OFF_W +: IDX_W];
    assign req_word    = fetch_addr_i[BYTE_W +: CNT_W];
    assign req_half    = fetch_addr_i[INSN_LSB +: HSEL_W];
    assign unused_lsbs = fetch_addr_i[INSN_LSB-1:0];

    icache_tag_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_i (req_idx),
        .rd_tag_i (req_tag),
        .hit_o    (hit),
        .wr_en_i  (line_set),
        .wr_idx_i (wr_idx),
        .wr_tag_i (line_tag)
    );

    icache_data_store #(
        .NUM_LINES   (NUM_LINES),
        .LINE_DWORDS (LINE_DWORDS),
        .DATA_W      (DATA_W),
        .INSN_W      (INSN_W),
        .IDX_W       (IDX_W),
        .CNT_W       (CNT_W),
        .HSEL_W      (HSEL_W)
    ) u_data (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_word_i (wr_word),
        .wr_data_i (wb_dat_i),
        .rd_idx_i  (req_idx),
        .rd_word_i (req_word),
        .rd_half_i (req_half),
        .insn_o    (fetch_insn_o)
    );

    icache_refill_ctrl #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .CNT_W  (CNT_W),
        .BYTE_W (BYTE_W)
    ) u_refill (
        .clk        (clk),
        .rst        (rst),
        .req_i      (fetch_req_i),
        .miss_i     (!hit),
        .req_tag_i  (req_tag),
        .req_idx_i  (req_idx),
        .wb_ack_i   (wb_ack_i),
        .wb_cyc_o   (busy),
        .wb_adr_o   (wb_adr_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_word_o  (wr_word),
        .line_set_o (line_set),
        .line_tag_o (line_tag)
    );

    assign fetch_ack_o = fetch_req_i && hit && !busy;
    assign wb_cyc_o    = busy;
    assign wb_stb_o    = busy;
    assign wb_we_o     = 1'b0;
    assign wb_sel_o    = '1;

    // R9
    ack_excl_bus_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_ack_o |-> !wb_cyc_o);

    // R4
    bus_read_only_chk: assert property (@(posedge clk) disable iff (rst)
        wb_cyc_o |-> wb_stb_o && !wb_we_o && (wb_sel_o == 8'hFF));

    // R1
    reset_miss_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !fetch_ack_o);

    // R8
    bus_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_cyc_o) |-> $past(fetch_req_i) && !$past(fetch_ack_o));

endmodule

// File: tb/insn_line_cache_tb.sv
module insn_line_cache_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_req;
    logic [63:0] fetch_addr;
    logic        fetch_ack;
    logic [31:0] fetch_insn;
    logic        wb_cyc, wb_stb, wb_we, wb_ack;
    logic [7:0]  wb_sel;
    logic [63:0] wb_adr, wb_dat;

    int n_chk = 0;
    int n_bad = 0;
    int lat   = 0;
    int wcnt  = 0;
    int beats = 0;
    logic [63:0] exp_base = '0;

    always #4 clk = ~clk;

    insn_line_cache u_dut (
        .clk          (clk),
        .rst          (rst),
        .fetch_req_i  (fetch_req),
        .fetch_addr_i (fetch_addr),
        .fetch_ack_o  (fetch_ack),
        .fetch_insn_o (fetch_insn),
        .wb_cyc_o     (wb_cyc),
        .wb_stb_o     (wb_stb),
        .wb_we_o      (wb_we),
        .wb_sel_o     (wb_sel),
        .wb_adr_o     (wb_adr),
        .wb_dat_i     (wb_dat),
        .wb_ack_i     (wb_ack)
    );

    function automatic logic [31:0] insn_of(input logic [63:0] word_addr);
        return (word_addr[31:0] * 32'h9E37_79B1) ^ word_addr[63:32] ^ 32'h0F0F_1234;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: registered ack after lat wait cycles
    always @(posedge clk) begin
        if (rst) begin
            wb_ack <= 1'b0;
            wcnt = 0;
        end else if (wb_cyc && wb_stb && !wb_ack) begin
            if (wcnt == lat) begin
                chk(wb_adr == exp_base + 64'(8 * beats), "R4 beat address", wb_adr, exp_base + 64'(8 * beats));
                chk(!wb_we && wb_sel == 8'hFF, "R4 read with all selects", {55'd0, wb_we, wb_sel}, 64'hFF);
                wb_dat <= {insn_of((wb_adr >> 2) + 64'd1), insn_of(wb_adr >> 2)};
                wb_ack <= 1'b1;
                beats++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end else begin
            wb_ack <= 1'b0;
        end
    end

    // R9 monitor
    always @(negedge clk) begin
        if (!rst && wb_cyc && fetch_ack) begin
            chk(1'b0, "R9 ack during bus cycle", 64'd1, 64'd0);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        fetch_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!fetch_ack && !wb_cyc, "R1 idle after reset", {62'd0, fetch_ack, wb_cyc}, 64'd0);
    endtask

    task automatic fetch(input logic [63:0] a, input bit expect_hit, input int bound);
        int n;
        @(negedge clk);
        if (!expect_hit) begin
            exp_base = {a[63:6], 6'd0};
            beats = 0;
        end
        fetch_req  = 1'b1;
        fetch_addr = a;
        #1;
        if (expect_hit) begin
            chk(fetch_ack, "R2 same-cycle hit ack", {63'd0, fetch_ack}, 64'd1);
            chk(fetch_insn == insn_of(a >> 2), "R3 hit word select", {32'd0, fetch_insn}, {32'd0, insn_of(a >> 2)});
            chk(!wb_cyc, "R8 no bus on hit", {63'd0, wb_cyc}, 64'd0);
        end else begin
            chk(!fetch_ack, "R4 miss keeps ack low (R7 R1)", {63'd0, fetch_ack}, 64'd0);
            n = 0;
            while (!fetch_ack && n < 400) begin
                @(posedge clk);
                #2;
                n++;
            end
            chk(fetch_ack, "R6 refill completes", {63'd0, fetch_ack}, 64'd1);
            chk(n <= bound, "R6 refill latency bound", 64'(n), 64'(bound));
            chk(beats == 8, "R6 full line before ack", 64'(beats), 64'd8);
            chk(fetch_insn == insn_of(a >> 2), "R3 refilled word", {32'd0, fetch_insn}, {32'd0, insn_of(a >> 2)});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] bases [6];
        int lats [3];
        int bound;
        bases[0] = 64'h0000_0000_0000_0000;
        bases[1] = 64'h0000_0000_0000_0040;
        bases[2] = 64'h0000_0000_0000_0080;
        bases[3] = 64'h0000_0000_0000_00C0;
        bases[4] = 64'hFFFF_FFFF_FFFF_FF40; // R7 aliases index 1
        bases[5] = 64'h0000_0000_0000_0100; // R7 aliases index 0
        lats[0] = 0; lats[1] = 1; lats[2] = 3;
        rst = 1'b1;
        fetch_req = 1'b0;
        fetch_addr = '0;
        wb_dat = '0;
        for (int li = 0; li < 3; li++) begin
            lat = lats[li];
            bound = (lat == 0) ? 30 : 8 * (lat + 2) + 4;
            do_reset();
            for (int bi = 0; bi < 6; bi++) begin
                int k0;
                k0 = (lat * 5 + bi * 3) % 16;
                fetch(bases[bi] + 64'(4 * k0), 1'b0, bound);
                for (int k = 0; k < 16; k++) begin
                    if (k != k0) fetch(bases[bi] + 64'(4 * k), 1'b1, bound);
                end
            end
            // R7 evictions and survivors
            fetch(64'h0000, 1'b0, bound);
            fetch(64'h0044, 1'b0, bound);
            fetch(64'h00C4, 1'b1, bound);
            fetch(64'h0088, 1'b1, bound);
            fetch(64'h0104, 1'b0, bound);
            // R1 mid-run reset forgets resident lines
            do_reset();
            fetch(64'h0004, 1'b0, bound);
            fetch(64'h0008, 1'b1, bound);
            fetch(64'h0100, 1'b0, bound);
            fetch(64'h0084, 1'b0, bound);
            fetch(64'h0004, 1'b0, bound);
            @(negedge clk);
            fetch_req = 1'b0;
            repeat (4) @(negedge clk);
            chk(!wb_cyc, "R8 idle without request", {63'd0, wb_cyc}, 64'd0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule